// File: doc/BRIEF.md
# Controlled-Slip Frame Elastic Store

This block absorbs the phase and frequency difference between a recovered receive line clock and a local system frame clock for a framed TDM octet stream. Octets arrive on the line side (`wr_clk`) and leave on the system side (`rd_clk`). The store holds two frames. A frame is 24 octets in T1 mode and 32 octets in E1 mode. It never lets a pointer run past the other. When the line side runs ahead, a complete incoming frame is discarded. When the system side runs ahead, the last complete frame is delivered a second time. In both cases the octet position within the frame is kept.

Each corrective event sets a sticky status bit in the system clock domain. The host sets three interrupt enables and clears status bits by writing a mask. The interrupt output is a registered OR of the enabled status bits. Frame pointers cross between the domains as 3-bit Gray counts through two-flop synchronizers. Line-side overflow events cross into the status logic through a toggle synchronizer.

Top module: `slip_elastic_store`

## Requirements
- R1: After reset the enables (bit 2 full, bit 1 empty, bit 0 slip), the status bits and `irq` are all 0, so no event raises `irq` until an enable is written.
- R2: With `e1_mode` = 0 a frame is 24 octets, and with `e1_mode` = 1 it is 32 octets. Frames that are read out return the octets in the order they were written, one octet per `rd_en` cycle, with `rd_data` valid one `rd_clk` cycle after the request.
- R3: After reset the read side lags the write side by one frame. The first frame read is a preload frame of undefined content, and the first frame written is the second frame read.
- R4: If a write starts a frame while two written frames are still unread, that whole incoming frame is discarded, the stored frames are kept, and status bit 2 (full) is set.
- R5: If a read starts a frame while no complete unread frame exists, the most recently read frame is delivered again in full, and status bit 1 (empty) is set.
- R6: Status bit 0 (slip) is set whenever either R4 or R5 occurs.
- R7: Status bits are sticky. A `sts_clr` pulse clears each bit whose `sts_clr_mask` bit is 1. If an event sets a bit in the same cycle that a clear targets it, the bit ends up set.
- R8: `irq` is 1 exactly one `rd_clk` cycle after some status bit and its matching enable (loaded by `cfg_we` from `cfg_irq_en`) are both 1.
- R9: A discard or a repeat is decided only at the first octet of a frame, so the frames that follow stay octet-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered line clock |
| wr_rst | input | 1 | Synchronous active-high reset, line domain |
| wr_en | input | 1 | One octet offered on `wr_data` this cycle |
| wr_data | input | 8 | Line octet |
| rd_clk | input | 1 | System frame clock; the host side also runs on it |
| rd_rst | input | 1 | Synchronous active-high reset, system domain |
| rd_en | input | 1 | Request one octet |
| rd_data | output | 8 | Octet requested in the previous cycle |
| e1_mode | input | 1 | 0 = 24-octet frames, 1 = 32-octet frames; change only under reset |
| cfg_we | input | 1 | Load the interrupt enables |
| cfg_irq_en | input | 3 | Enables: bit 2 full, bit 1 empty, bit 0 slip |
| sts_clr | input | 1 | Clear strobe for status bits |
| sts_clr_mask | input | 3 | Bits to clear when `sts_clr` is 1 |
| slip_sts | output | 3 | Sticky status: bit 2 full, bit 1 empty, bit 0 slip |
| irq | output | 1 | Registered OR of enabled status bits |

## Verification
Two functions can land on the same `rd_clk` edge. An underflow repeat sets the empty and slip bits, and a host clear strobe can target the same status register on that edge. The bench raises `sts_clr` with an all-ones mask on exactly the cycle that requests the first octet of a frame from an empty store. Before that edge the full bit is already set from an earlier overflow. The outcome is judged from `slip_sts`: the full bit must be cleared while the empty and slip bits stay set, and the repeated frame must still come out intact.

// File: rtl/slip_pkg.sv
`timescale 1ns/1ps
package slip_pkg;
  // status / enable bit positions
  localparam int STS_FULL  = 2;
  localparam int STS_EMPTY = 1;
  localparam int STS_SLIP  = 0;
  localparam int STS_W     = 3;
  // frames held in storage
  localparam int FRAMES_HELD = 2;

  typedef enum logic {
    MODE_T1 = 1'b0,
    MODE_E1 = 1'b1
  } line_mode_e;
endpackage

// File: rtl/slip_ptr_cdc.sv
`timescale 1ns/1ps
// Binary frame count -> Gray register -> two-flop sync -> binary
module slip_ptr_cdc #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic [W-1:0] dst_bin
);
  localparam logic [W-1:0] RST_GRAY = RST_VAL ^ (RST_VAL >> 1);

  logic [W-1:0] src_gray;
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge src_clk) begin
    if (src_rst) src_gray <= RST_GRAY;
    else         src_gray <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      meta_q <= RST_GRAY;
      sync_q <= RST_GRAY;
    end else begin
      meta_q <= src_gray;
      sync_q <= meta_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign dst_bin[i] = ^sync_q[W-1:i];
  end
endmodule

// File: rtl/slip_pulse_cdc.sv
`timescale 1ns/1ps
// Single-cycle event crossing via toggle and three flops
module slip_pulse_cdc (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_pulse
);
  logic tog_q;
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge src_clk) begin
    if (src_rst)        tog_q <= 1'b0;
    else if (src_pulse) tog_q <= ~tog_q;
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tog_q;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign dst_pulse = s2_q ^ s3_q;
endmodule

// File: rtl/slip_frame_ram.sv
`timescale 1ns/1ps
// Simple dual-port, dual-clock RAM with registered read
module slip_frame_ram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/slip_wr_ctrl.sv
`timescale 1ns/1ps
// Line side: octet/frame counting and whole-frame discard on overflow
module slip_wr_ctrl
  import slip_pkg::*;
#(
  parameter int T1_LEN = 24,
  parameter int E1_LEN = 32,
  parameter int OCT_W  = 5,
  parameter int FW     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             e1_mode,
  input  logic             wr_en,
  input  logic [FW-1:0]    rd_frm_sync,
  output logic             mem_we,
  output logic [OCT_W:0]   mem_addr,
  output logic [FW-1:0]    wr_frm,
  output logic [OCT_W-1:0] wr_oct,
  output logic             evt_full
);
  localparam logic [OCT_W-1:0] T1_LAST = OCT_W'(T1_LEN - 1);
  localparam logic [OCT_W-1:0] E1_LAST = OCT_W'(E1_LEN - 1);
  localparam logic [FW-1:0]    LIMIT   = FW'(FRAMES_HELD);

  logic [OCT_W-1:0] oct_q;
  logic [FW-1:0]    frm_q;
  logic             drop_q;
  logic [OCT_W-1:0] last_oct;
  logic [FW-1:0]    ahead;
  logic             at_first;
  logic             drop_now;

  assign last_oct = (line_mode_e'(e1_mode) == MODE_E1) ? E1_LAST : T1_LAST;
  assign ahead    = frm_q - rd_frm_sync;
  assign at_first = (oct_q == '0);
  assign evt_full = wr_en && at_first && (ahead >= LIMIT);
  assign drop_now = evt_full || (drop_q && !at_first);

  assign mem_we   = wr_en && !drop_now;
  assign mem_addr = {frm_q[0], oct_q};
  assign wr_frm   = frm_q;
  assign wr_oct   = oct_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oct_q  <= '0;
      frm_q  <= FW'(1);
      drop_q <= 1'b0;
    end else if (wr_en) begin
      drop_q <= drop_now;
      if (oct_q == last_oct) begin
        oct_q <= '0;
        if (!drop_now) frm_q <= frm_q + 1'b1;
      end else begin
        oct_q <= oct_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slip_rd_ctrl.sv
`timescale 1ns/1ps
// System side: octet/frame counting and whole-frame repeat on underflow
module slip_rd_ctrl
  import slip_pkg::*;
#(
  parameter int T1_LEN = 24,
  parameter int E1_LEN = 32,
  parameter int OCT_W  = 5,
  parameter int FW     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             e1_mode,
  input  logic             rd_en,
  input  logic [FW-1:0]    wr_frm_sync,
  output logic             mem_re,
  output logic [OCT_W:0]   mem_addr,
  output logic [FW-1:0]    rd_frm,
  output logic [OCT_W-1:0] rd_oct,
  output logic             evt_empty
);
  localparam logic [OCT_W-1:0] T1_LAST = OCT_W'(T1_LEN - 1);
  localparam logic [OCT_W-1:0] E1_LAST = OCT_W'(E1_LEN - 1);

  logic [OCT_W-1:0] oct_q;
  logic [FW-1:0]    frm_q;
  logic [OCT_W-1:0] last_oct;
  logic [FW-1:0]    src_frm;

  assign last_oct  = (line_mode_e'(e1_mode) == MODE_E1) ? E1_LAST : T1_LAST;
  assign evt_empty = rd_en && (oct_q == '0) && (frm_q == wr_frm_sync);
  assign src_frm   = evt_empty ? frm_q - 1'b1 : frm_q;

  assign mem_re   = rd_en;
  assign mem_addr = {src_frm[0], oct_q};
  assign rd_frm   = frm_q;
  assign rd_oct   = oct_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oct_q <= '0;
      frm_q <= '0;
    end else if (rd_en) begin
      if (oct_q == last_oct) begin
        oct_q <= '0;
        frm_q <= src_frm + 1'b1;
      end else begin
        oct_q <= oct_q + 1'b1;
        frm_q <= src_frm;
      end
    end
  end
endmodule

// File: rtl/slip_irq_status.sv
`timescale 1ns/1ps
// Sticky status, enables and interrupt in the system domain
module slip_irq_status
  import slip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_full,
  input  logic              set_empty,
  input  logic              cfg_we,
  input  logic [STS_W-1:0]  cfg_en,
  input  logic              clr_stb,
  input  logic [STS_W-1:0]  clr_mask,
  output logic [STS_W-1:0]  sts,
  output logic [STS_W-1:0]  en,
  output logic              irq
);
  logic [STS_W-1:0] set_vec;

  assign set_vec[STS_FULL]  = set_full;
  assign set_vec[STS_EMPTY] = set_empty;
  assign set_vec[STS_SLIP]  = set_full | set_empty;

  for (genvar b = 0; b < STS_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        sts[b] <= 1'b0;
        en[b]  <= 1'b0;
      end else begin
        if (set_vec[b])                  sts[b] <= 1'b1;
        else if (clr_stb && clr_mask[b]) sts[b] <= 1'b0;
        if (cfg_we) en[b] <= cfg_en[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(sts & en);
  end
endmodule

// File: rtl/slip_elastic_store.sv
`timescale 1ns/1ps
module slip_elastic_store
  import slip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int T1_LEN = 24,
  parameter int E1_LEN = 32,
  parameter int FRM_W  = 3
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              e1_mode,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_irq_en,
  input  logic              sts_clr,
  input  logic [2:0]        sts_clr_mask,
  output logic [2:0]        slip_sts,
  output logic              irq
);
  localparam int OCT_W  = $clog2(E1_LEN);
  localparam int ADDR_W = OCT_W + 1;

  logic              wr_mem_we;
  logic [ADDR_W-1:0] wr_addr;
  logic [FRM_W-1:0]  wr_frm;
  logic [OCT_W-1:0]  wr_oct;
  logic              wr_evt_full;
  logic [FRM_W-1:0]  rd_frm_at_wr;

  logic              rd_mem_re;
  logic [ADDR_W-1:0] rd_addr;
  logic [FRM_W-1:0]  rd_frm;
  logic [OCT_W-1:0]  rd_oct;
  logic              rd_evt_empty;
  logic [FRM_W-1:0]  wr_frm_at_rd;
  logic              full_at_rd;
  logic [2:0]        irq_en_q;

  slip_wr_ctrl #(
    .T1_LEN(T1_LEN), .E1_LEN(E1_LEN), .OCT_W(OCT_W), .FW(FRM_W)
  ) u_wr (
    .clk(wr_clk), .rst(wr_rst), .e1_mode(e1_mode), .wr_en(wr_en),
    .rd_frm_sync(rd_frm_at_wr), .mem_we(wr_mem_we), .mem_addr(wr_addr),
    .wr_frm(wr_frm), .wr_oct(wr_oct), .evt_full(wr_evt_full)
  );

  slip_rd_ctrl #(
    .T1_LEN(T1_LEN), .E1_LEN(E1_LEN), .OCT_W(OCT_W), .FW(FRM_W)
  ) u_rd (
    .clk(rd_clk), .rst(rd_rst), .e1_mode(e1_mode), .rd_en(rd_en),
    .wr_frm_sync(wr_frm_at_rd), .mem_re(rd_mem_re), .mem_addr(rd_addr),
    .rd_frm(rd_frm), .rd_oct(rd_oct), .evt_empty(rd_evt_empty)
  );

  slip_ptr_cdc #(.W(FRM_W), .RST_VAL(FRM_W'(1))) u_wptr_sync (
    .src_clk(wr_clk), .src_rst(wr_rst), .src_bin(wr_frm),
    .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_bin(wr_frm_at_rd)
  );

  slip_ptr_cdc #(.W(FRM_W), .RST_VAL('0)) u_rptr_sync (
    .src_clk(rd_clk), .src_rst(rd_rst), .src_bin(rd_frm),
    .dst_clk(wr_clk), .dst_rst(wr_rst), .dst_bin(rd_frm_at_wr)
  );

  slip_pulse_cdc u_full_sync (
    .src_clk(wr_clk), .src_rst(wr_rst), .src_pulse(wr_evt_full),
    .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_pulse(full_at_rd)
  );

  slip_frame_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(wr_mem_we), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_mem_re), .raddr(rd_addr), .rdata(rd_data)
  );

  slip_irq_status u_sts (
    .clk(rd_clk), .rst(rd_rst), .set_full(full_at_rd), .set_empty(rd_evt_empty),
    .cfg_we(cfg_we), .cfg_en(cfg_irq_en), .clr_stb(sts_clr),
    .clr_mask(sts_clr_mask), .sts(slip_sts), .en(irq_en_q), .irq(irq)
  );
endmodule

// File: rtl/slip_elastic_store_chk.sv
`timescale 1ns/1ps
module slip_elastic_store_chk #(
  parameter int FW    = 3,
  parameter int OCT_W = 5
) (
  input logic             rd_clk,
  input logic             rd_rst,
  input logic             wr_clk,
  input logic             wr_rst,
  input logic             irq,
  input logic [2:0]       sts,
  input logic [2:0]       en,
  input logic             sts_clr,
  input logic [2:0]       sts_clr_mask,
  input logic             rd_evt_empty,
  input logic [FW-1:0]    rd_frm,
  input logic [OCT_W-1:0] rd_oct,
  input logic             wr_evt_full,
  input logic [OCT_W-1:0] wr_oct
);
  logic [2:0] keep;
  assign keep = sts & ~({3{sts_clr}} & sts_clr_mask);

  AST_RESET_QUIET: assert property (@(posedge rd_clk)
    rd_rst |=> (en == 3'b000 && sts == 3'b000 && !irq)); // R1

  AST_FULL_AT_BOUNDARY: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_evt_full |-> (wr_oct == '0)); // R9

  AST_EMPTY_AT_BOUNDARY: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_evt_empty |-> (rd_oct == '0)); // R9

  AST_EMPTY_MARKS: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_evt_empty |=> (sts[1] && sts[0])); // R6

  AST_STICKY_HOLD: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (keep != 3'b000) |=> ((sts & $past(keep)) == $past(keep))); // R7

  AST_IRQ_GATED: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (en == 3'b000) |=> !irq); // R8

  AST_RD_FRAME_STEP: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !$stable(rd_frm) |-> (rd_frm == $past(rd_frm) + 1'b1 ||
                          rd_frm == $past(rd_frm) - 1'b1)); // R5
endmodule

bind slip_elastic_store slip_elastic_store_chk #(.FW(FRM_W), .OCT_W(OCT_W)) u_chk (
  .rd_clk(rd_clk), .rd_rst(rd_rst), .wr_clk(wr_clk), .wr_rst(wr_rst),
  .irq(irq), .sts(slip_sts), .en(irq_en_q), .sts_clr(sts_clr),
  .sts_clr_mask(sts_clr_mask), .rd_evt_empty(rd_evt_empty), .rd_frm(rd_frm),
  .rd_oct(rd_oct), .wr_evt_full(wr_evt_full), .wr_oct(wr_oct)
);

// File: tb/slip_elastic_store_test.sv
`timescale 1ns/1ps
module slip_elastic_store_test;
  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst = 1'b1, rd_rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       e1_mode = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_irq_en = '0;
  logic       sts_clr = 1'b0;
  logic [2:0] sts_clr_mask = '0;
  logic [2:0] slip_sts;
  logic       irq;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] got [32];

  always #5 rd_clk = ~rd_clk;   // 100 MHz system side
  always #6 wr_clk = ~wr_clk;   // line side

  slip_elastic_store uut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
    .e1_mode(e1_mode), .cfg_we(cfg_we), .cfg_irq_en(cfg_irq_en),
    .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask), .slip_sts(slip_sts), .irq(irq)
  );

  function automatic int flen();
    return e1_mode ? 32 : 24;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_frame(input string req, input logic [7:0] base);
    int bad = -1;
    for (int i = 0; i < flen(); i++)
      if (bad < 0 && got[i] !== 8'(base + i)) bad = i;
    n_run++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s octet %0d actual=%0h expected=%0h", req, bad, got[bad], 8'(base + bad));
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rd_clk);
    repeat (10) @(negedge wr_clk);
  endtask

  task automatic do_reset(input logic mode);
    e1_mode = mode;
    wr_rst = 1'b1; rd_rst = 1'b1;
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    wr_rst = 1'b0; rd_rst = 1'b0;
    settle();
  endtask

  task automatic write_frame(input logic [7:0] base);
    for (int i = 0; i < flen(); i++) begin
      @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = 8'(base + i);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
    settle();
  endtask

  task automatic read_frame(input logic [2:0] clr);
    @(negedge rd_clk);
    rd_en = 1'b1;
    sts_clr = (clr != 3'b000);
    sts_clr_mask = clr;
    for (int i = 0; i < flen(); i++) begin
      @(negedge rd_clk);
      got[i] = rd_data;
      sts_clr = 1'b0;
      if (i == flen() - 1) rd_en = 1'b0;
    end
    settle();
  endtask

  task automatic set_en(input logic [2:0] v);
    @(negedge rd_clk);
    cfg_we = 1'b1; cfg_irq_en = v;
    @(negedge rd_clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic clear_sts(input logic [2:0] m);
    @(negedge rd_clk);
    sts_clr = 1'b1; sts_clr_mask = m;
    @(negedge rd_clk);
    sts_clr = 1'b0;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic t_reset();
    check("R1 status after reset", slip_sts, 3'b000);
    check("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_passthrough(input logic [7:0] base, input string req);
    write_frame(base);
    read_frame(3'b000);                 // preload frame, content undefined
    read_frame(3'b000);
    check_frame({req, " R3 first written frame is second read"}, base);
    check({req, " no slip on balanced flow"}, slip_sts, 3'b000);
  endtask

  task automatic t_underflow(input logic [7:0] base, input string req);
    read_frame(3'b000);
    check_frame({req, " R5 repeated frame"}, base);
    check({req, " R5 R6 empty and slip set"}, slip_sts, 3'b011);
  endtask

  task automatic t_irq();
    check("R1 irq stays 0 with default enables", irq, 1'b0);
    set_en(3'b010);
    check("R8 irq with empty enabled", irq, 1'b1);
    set_en(3'b100);
    check("R8 irq masked when only full enabled", irq, 1'b0);
    set_en(3'b001);
    check("R8 irq with slip enabled", irq, 1'b1);
    clear_sts(3'b011);
    check("R7 clear by mask", slip_sts, 3'b000);
    check("R8 irq drops after clear", irq, 1'b0);
  endtask

  task automatic t_overflow();
    write_frame(8'h40);
    write_frame(8'h60);
    check("R4 no full while one frame free", slip_sts, 3'b000);
    write_frame(8'h80);                 // store holds two unread frames
    check("R4 R6 full and slip set", slip_sts, 3'b101);
    check("R8 irq from slip enable", irq, 1'b1);
    read_frame(3'b000);
    check_frame("R4 first kept frame", 8'h40);
    read_frame(3'b000);
    check_frame("R4 R9 second kept frame, dropped one absent", 8'h60);
  endtask

  task automatic t_collision();
    // full bit is set; clear all bits on the very cycle an underflow begins
    read_frame(3'b111);
    check("R7 set wins over same-cycle clear", slip_sts, 3'b011);
    check_frame("R5 repeat during clear", 8'h60);
  endtask

  task automatic t_after_slip();
    write_frame(8'hC0);
    read_frame(3'b000);
    check_frame("R9 alignment after slips", 8'hC0);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset();
    t_passthrough(8'h10, "R2 T1");
    t_underflow(8'h10, "T1");
    t_irq();
    t_overflow();
    t_collision();
    t_after_slip();
    do_reset(1'b1);
    t_reset();
    t_passthrough(8'hA0, "R2 E1");
    t_underflow(8'hA0, "E1");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1-all actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule